// File: doc/BRIEF.md
# Pipelined Split-Transaction Bus Controller

This block is the central controller for a small shared memory bus with three agents. Agents 0 and 1 are requesters, and agent 2 is the memory agent. Each agent has its own request wire and its own grant wire. A round-robin arbiter picks one winner per cycle. The winner then owns the command lines for the next cycle, the address lines for the cycle after that, and, for writes and replies, the data lines one cycle later. Because each phase holds only one transaction at a time, up to four transactions can be in flight at once: one being granted, one on command, one on address and one on data.

Reads are split. A read request occupies only the command and address phases and never waits for data. Later the memory agent competes for the bus like any other agent. It issues a data-response command, drives the original address and the echoed tag, and then drives the read data. The controller stamps each requester's address phase with that requester's index as its tag. It records one outstanding read per requester and flags the data phase of a reply whose tag and address both match that record.

All agents share one externally supplied clock. Reset is synchronous and active low.

Top module: `split_bus_ctrl`

## Requirements
- R1: While reset is asserted, no grant is given. After reset, the command, address and data phases are idle, no read is outstanding, and the round-robin pointer favours agent 0.
- R2: The grant output has at most one bit set. A bit can only be set for an agent whose request is high in the same cycle, and the grant is combinational from the request.
- R3: Arbitration searches the agents from the pointer upward, wrapping from 2 back to 0. After a grant to agent k, the pointer moves to (k+1) mod 3.
- R4: In the cycle after a grant, `cmd_vld` is 1, `cmd_own` is the winner, and `bus_cmd` carries that agent's command. The command encoding is 0 idle, 1 read, 2 write, 3 data response. An idle command starts no address phase.
- R5: One cycle after a non-idle command phase, `addr_vld` is 1, `addr_own` is the same agent, and `bus_addr` carries that agent's address.
- R6: One cycle after the address phase of a write or a data response, `data_vld` is 1 and `bus_data` carries the owner's data. A read has no data phase.
- R7: During the address phase, `bus_tag` equals the owner's index for agents 0 and 1. For the memory agent, `bus_tag` passes through `mem_tag`.
- R8: A grant can be made in every cycle. Back-to-back grants occupy the command, address and data phases in successive cycles, and each phase carries a different transaction.
- R9: A read's address phase sets `rd_pend` for its requester in the next cycle. During the data phase of a data response, `rsp_hit` is raised for requester i only if the tag equals i and the address equals the recorded read address. A hit clears `rd_pend`. A reply with a mismatched tag or address leaves the record in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 3 | Request line per agent |
| gnt | output | 3 | Grant line per agent |
| agt_cmd | input | 6 | Command from each agent, 2 bits per agent |
| agt_addr | input | 48 | Address from each agent, 16 bits per agent |
| agt_data | input | 96 | Data from each agent, 32 bits per agent |
| mem_tag | input | 2 | Echoed tag driven by the memory agent for a reply |
| cmd_vld | output | 1 | Command phase occupied |
| cmd_own | output | 2 | Owner of the command phase |
| bus_cmd | output | 2 | Command lines |
| addr_vld | output | 1 | Address phase occupied |
| addr_own | output | 2 | Owner of the address phase |
| bus_addr | output | 16 | Address lines |
| bus_tag | output | 2 | Transaction tag lines |
| data_vld | output | 1 | Data phase occupied |
| data_own | output | 2 | Owner of the data phase |
| bus_data | output | 32 | Data lines |
| rd_pend | output | 3 | Outstanding read per requester (bit 2 always 0) |
| rsp_hit | output | 3 | Reply matches requester's outstanding read (bit 2 always 0) |

## Verification
The results fall due at fixed offsets from the grant:
- The grant is visible in the request cycle itself.
- The command phase follows one cycle later, the address phase two cycles later, and the data phase and `rsp_hit` three cycles later.
- `rd_pend` changes one cycle after the address or data phase that updates it.

The bench drives every input just after a falling edge and samples 1 ns later, inside the same cycle. Each scenario task steps through these cycles one at a time and checks only the outputs due in that cycle. The bench's memory model raises its request four cycles after the read's address phase. Each reply's phases are therefore checked at grant+1, grant+2 and grant+3 of the reply's own grant.

// File: rtl/split_bus_ctrl.sv
module split_bus_ctrl #(
  parameter int N_AGT = 3,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IDW   = 2,
  localparam int OW   = $clog2(N_AGT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_AGT-1:0]   req,
  output logic [N_AGT-1:0]   gnt,
  input  logic [N_AGT*2-1:0] agt_cmd,
  input  logic [N_AGT*AW-1:0] agt_addr,
  input  logic [N_AGT*DW-1:0] agt_data,
  input  logic [IDW-1:0]     mem_tag,
  output logic               cmd_vld,
  output logic [OW-1:0]      cmd_own,
  output logic [1:0]         bus_cmd,
  output logic               addr_vld,
  output logic [OW-1:0]      addr_own,
  output logic [AW-1:0]      bus_addr,
  output logic [IDW-1:0]     bus_tag,
  output logic               data_vld,
  output logic [OW-1:0]      data_own,
  output logic [DW-1:0]      bus_data,
  output logic [N_AGT-1:0]   rd_pend,
  output logic [N_AGT-1:0]   rsp_hit
);
  localparam int MEM = N_AGT - 1;
  localparam logic [1:0] C_IDLE = 2'd0;
  localparam logic [1:0] C_RD   = 2'd1;
  localparam logic [1:0] C_RSP  = 2'd3;

  function automatic logic [OW-1:0] rr_idx(input logic [OW-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= N_AGT) s = s - N_AGT;
    return OW'(s);
  endfunction

  // arbitration
  logic [OW-1:0] ptr, win;
  logic          any;

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int k = 0; k < N_AGT; k++) begin
      if (!any && req[rr_idx(ptr, k)]) begin
        any = 1'b1;
        win = rr_idx(ptr, k);
      end
    end
  end

  assign gnt = (any && rst_n) ? (N_AGT'(1) << win) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (any) ptr <= rr_idx(win, 1);
  end

  // command phase
  logic          c_v;
  logic [OW-1:0] c_own;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_v   <= 1'b0;
      c_own <= '0;
    end else begin
      c_v   <= any;
      c_own <= win;
    end
  end

  assign cmd_vld = c_v;
  assign cmd_own = c_own;
  assign bus_cmd = c_v ? agt_cmd[c_own*2 +: 2] : C_IDLE;

  // address phase
  logic          a_v;
  logic [OW-1:0] a_own;
  logic [1:0]    a_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_v   <= 1'b0;
      a_own <= '0;
      a_cmd <= C_IDLE;
    end else begin
      a_v   <= c_v && (bus_cmd != C_IDLE);
      a_own <= c_own;
      a_cmd <= bus_cmd;
    end
  end

  assign addr_vld = a_v;
  assign addr_own = a_own;
  assign bus_addr = a_v ? agt_addr[a_own*AW +: AW] : '0;
  assign bus_tag  = !a_v ? '0 : (a_own == OW'(MEM)) ? mem_tag : IDW'(a_own);

  // data phase
  logic           d_v;
  logic [OW-1:0]  d_own;
  logic [1:0]     d_cmd;
  logic [AW-1:0]  d_addr;
  logic [IDW-1:0] d_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_v    <= 1'b0;
      d_own  <= '0;
      d_cmd  <= C_IDLE;
      d_addr <= '0;
      d_tag  <= '0;
    end else begin
      d_v    <= a_v && (a_cmd != C_RD);
      d_own  <= a_own;
      d_cmd  <= a_cmd;
      d_addr <= bus_addr;
      d_tag  <= bus_tag;
    end
  end

  assign data_vld = d_v;
  assign data_own = d_own;
  assign bus_data = d_v ? agt_data[d_own*DW +: DW] : '0;

  // outstanding read per requester
  for (genvar i = 0; i < N_AGT; i++) begin : g_pend
    if (i < MEM) begin : g_req
      logic          pv;
      logic [AW-1:0] pa;
      logic          set_i;
      assign set_i      = a_v && (a_cmd == C_RD) && (a_own == OW'(i));
      assign rsp_hit[i] = d_v && (d_cmd == C_RSP) && (d_tag == IDW'(i)) && pv && (d_addr == pa);
      assign rd_pend[i] = pv;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pv <= 1'b0;
          pa <= '0;
        end else if (set_i) begin
          pv <= 1'b1;
          pa <= bus_addr;
        end else if (rsp_hit[i]) begin
          pv <= 1'b0;
        end
      end
    end else begin : g_mem
      assign rsp_hit[i] = 1'b0;
      assign rd_pend[i] = 1'b0;
    end
  end

  // R2
  gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R3
  for (genvar k = 0; k < N_AGT; k++) begin : g_rr_chk
    localparam int NK = (k + 1) % N_AGT;
    rr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req[NK] && $past(gnt[k])) |-> gnt[NK]);
  end

  // R4
  cmd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> (cmd_vld && ((N_AGT'(1) << cmd_own) == $past(gnt))));

  // R5
  addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && bus_cmd != C_IDLE) |=> (addr_vld && addr_own == $past(cmd_own)));

  // R6
  rd_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && a_cmd == C_RD) |=> !data_vld);

  // R9
  hit_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit & ~rd_pend) == '0);

  // R9
  hit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_hit) |=> ((rd_pend & $past(rsp_hit)) == '0));
endmodule

// File: tb/split_bus_ctrl_test.sv
`timescale 1ns/1ps
module split_bus_ctrl_test;
  localparam logic [1:0] C_IDLE = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_RSP = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic [2:0]  gnt;
  logic [5:0]  agt_cmd = '0;
  logic [47:0] agt_addr = '0;
  logic [95:0] agt_data = '0;
  logic [1:0]  mem_tag = '0;
  logic        cmd_vld, addr_vld, data_vld;
  logic [1:0]  cmd_own, addr_own, data_own, bus_cmd, bus_tag;
  logic [15:0] bus_addr;
  logic [31:0] bus_data;
  logic [2:0]  rd_pend, rsp_hit;

  split_bus_ctrl uut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, eptr = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int rr_pick(input logic [2:0] r, input int p);
    for (int k = 0; k < 3; k++) if (r[(p + k) % 3]) return (p + k) % 3;
    return -1;
  endfunction

  task automatic set_agt(input int i, input logic [1:0] c, input logic [15:0] a, input logic [31:0] d);
    agt_cmd[i*2 +: 2]   = c;
    agt_addr[i*16 +: 16] = a;
    agt_data[i*32 +: 32] = d;
  endtask

  task automatic grant_step(input logic [2:0] r, input string rq);
    int w;
    @(negedge clk);
    req = r;
    #1;
    w = rr_pick(r, eptr);
    chk(rq, "gnt", gnt, (w < 0) ? 64'd0 : (64'd1 << w));
    if (w >= 0) eptr = (w + 1) % 3;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req = '0;
    #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    req = 3'b111;
    #1;
    chk("R1", "gnt during reset", gnt, 0);
    chk("R1", "cmd_vld during reset", cmd_vld, 0);
    chk("R1", "addr_vld during reset", addr_vld, 0);
    chk("R1", "data_vld during reset", data_vld, 0);
    chk("R1", "rd_pend during reset", rd_pend, 0);
    @(negedge clk);
    req = '0;
    rst_n = 1'b1;
    #1;
    chk("R1", "cmd_vld after reset", cmd_vld, 0);
    eptr = 0;
  endtask

  task automatic t_rr();
    logic [2:0] pats [9] = '{3'b111, 3'b111, 3'b111, 3'b110, 3'b101, 3'b011, 3'b001, 3'b100, 3'b000};
    logic prevg = 1'b0;
    for (int i = 0; i < 9; i++) begin
      grant_step(pats[i], "R3");
      chk("R4", "cmd_vld after grant", cmd_vld, prevg);
      chk("R4", "idle command opens no address phase", addr_vld, 0);
      prevg = (pats[i] != 3'b000);
    end
    repeat (3) idle_cycle();
  endtask

  task automatic t_write();
    set_agt(1, C_WR, 16'h1234, 32'hA5A5_0001);
    grant_step(3'b010, "R2");
    idle_cycle();
    chk("R4", "cmd_vld", cmd_vld, 1);
    chk("R4", "cmd_own", cmd_own, 1);
    chk("R4", "bus_cmd", bus_cmd, C_WR);
    idle_cycle();
    chk("R5", "addr_vld", addr_vld, 1);
    chk("R5", "addr_own", addr_own, 1);
    chk("R5", "bus_addr", bus_addr, 16'h1234);
    chk("R7", "bus_tag requester", bus_tag, 1);
    idle_cycle();
    chk("R6", "data_vld", data_vld, 1);
    chk("R6", "data_own", data_own, 1);
    chk("R6", "bus_data", bus_data, 32'hA5A5_0001);
    idle_cycle();
    chk("R6", "data phase ends", data_vld, 0);
    set_agt(1, C_IDLE, 0, 0);
  endtask

  task automatic t_burst();
    int w [3];
    int p;
    logic [2:0] rem;
    for (int i = 0; i < 3; i++) set_agt(i, (i == 2) ? C_RSP : C_WR, 16'h0100 + 16'(i), 32'h0000_00D0 + 32'(i));
    mem_tag = 2'd3;
    p = eptr;
    rem = 3'b111;
    for (int k = 0; k < 3; k++) begin
      w[k] = rr_pick(rem, p);
      p = (w[k] + 1) % 3;
      rem[w[k]] = 1'b0;
    end
    rem = 3'b111;
    for (int k = 0; k < 6; k++) begin
      grant_step(rem, "R8");
      if (k < 3) rem[w[k]] = 1'b0;
      if (k >= 1 && k <= 3) begin
        chk("R8", "cmd_own", cmd_own, w[k-1]);
        chk("R8", "bus_cmd", bus_cmd, (w[k-1] == 2) ? C_RSP : C_WR);
      end
      if (k >= 2 && k <= 4) begin
        chk("R8", "addr_vld", addr_vld, 1);
        chk("R8", "addr_own", addr_own, w[k-2]);
        chk("R8", "bus_addr", bus_addr, 16'h0100 + 16'(w[k-2]));
        chk("R7", "bus_tag", bus_tag, (w[k-2] == 2) ? 2'd3 : 2'(w[k-2]));
      end
      if (k >= 3) begin
        chk("R8", "data_vld", data_vld, 1);
        chk("R8", "data_own", data_own, w[k-3]);
        chk("R8", "bus_data", bus_data, 32'h0000_00D0 + 32'(w[k-3]));
        chk("R9", "no hit without pending read", rsp_hit, 0);
      end
    end
    for (int i = 0; i < 3; i++) set_agt(i, C_IDLE, 0, 0);
    mem_tag = 2'd0;
    idle_cycle();
  endtask

  task automatic t_read(input int a, input logic [15:0] addr);
    set_agt(a, C_RD, addr, 32'h0);
    grant_step(3'b001 << a, "R9");
    idle_cycle();
    chk("R4", "read command", bus_cmd, C_RD);
    idle_cycle();
    chk("R5", "read address", bus_addr, addr);
    chk("R7", "read tag", bus_tag, a);
    idle_cycle();
    chk("R6", "read has no data phase", data_vld, 0);
    chk("R9", "rd_pend set", rd_pend[a], 1);
    set_agt(a, C_IDLE, 0, 0);
  endtask

  task automatic mem_reply(input logic [1:0] tag, input logic [15:0] addr, input logic [31:0] d,
                           input logic [2:0] exp_hit, input logic [2:0] exp_pend);
    set_agt(2, C_RSP, addr, d);
    mem_tag = tag;
    repeat (2) idle_cycle();
    grant_step(3'b100, "R6");
    idle_cycle();
    chk("R4", "reply command", bus_cmd, C_RSP);
    chk("R4", "reply cmd_own", cmd_own, 2);
    idle_cycle();
    chk("R5", "reply address", bus_addr, addr);
    chk("R7", "reply tag passthrough", bus_tag, tag);
    idle_cycle();
    chk("R6", "reply data_vld", data_vld, 1);
    chk("R6", "reply data_own", data_own, 2);
    chk("R6", "reply data", bus_data, d);
    chk("R9", "rsp_hit", rsp_hit, exp_hit);
    idle_cycle();
    chk("R9", "rd_pend after reply", rd_pend, exp_pend);
    chk("R9", "rsp_hit pulse ends", rsp_hit, 0);
    set_agt(2, C_IDLE, 0, 0);
    mem_tag = 2'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rr();
    t_write();
    t_burst();
    t_read(0, 16'h2222);
    mem_reply(2'd0, 16'h2222, 32'hBEEF_0000, 3'b001, 3'b000);
    t_read(1, 16'h3333);
    mem_reply(2'd1, 16'h3334, 32'h1111_0000, 3'b000, 3'b010);
    mem_reply(2'd0, 16'h3333, 32'h2222_0000, 3'b000, 3'b010);
    mem_reply(2'd1, 16'h3333, 32'h3333_0000, 3'b010, 3'b000);
    repeat (2) idle_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule